// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block watches up to 32 level-sensitive interrupt request lines. Each line has its own programmed priority level, register-set number and non-maskable flag. In every clock cycle the block finds the enabled, pending line with the highest level. It then places a record for the processor on a streaming output. The record carries:

- a valid flag,
- the winning level,
- the register-set number,
- the non-maskable flag,
- a handler address, computed as a programmable base plus the winning line's index times a programmable spacing.

Software sets up the block through a word-addressed register port. Reads return data in the same cycle. Writes take effect at the next clock edge.

Instances can be chained. A streaming input accepts the record produced by an upstream controller. The local controller forwards that record unchanged when its level is strictly higher than the best local candidate, or when no local line is active. When neither source is active, the output record is all zero. The output is registered, so the record appears one cycle after the inputs that caused it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the output record is all zero, every enable bit is clear, and every per-line configuration word reads zero.
- R2: The configuration word of line k is at word address k (0..31). Its fields are level in bits 5:0, register set in bits 11:6 and non-maskable in bit 12. Writes to other bits are dropped, and those bits read as zero.
- R3: Writing ones to address 0x20 sets those enable bits. Writing ones to address 0x21 clears those enable bits. Zero bits leave the mask alone in both cases. Reading either address returns the enable mask.
- R4: Address 0x22 reads the raw request lines, whatever the enables are.
- R5: A line whose enable bit is clear or whose level is 0 never produces a record.
- R6: Among active local lines the highest level wins. On equal levels, the lower index wins.
- R7: The record carries the winner's level, register-set number and non-maskable flag.
- R8: The local handler address is the base (address 0x23) plus the winning index times 16 << s. Here s is bits 1:0 of address 0x24, giving spacings of 16, 32, 64 or 128 bytes.
- R9: A valid upstream record is forwarded with all its fields unchanged when no local line is active or when its level is strictly higher than the best local level. On equal levels, the local line wins.
- R10: When the record is not valid, its level, register set, non-maskable flag and address are all zero.
- R11: The record is registered. It reflects the request lines, upstream record and configuration as they stood at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 32 | Level-sensitive interrupt requests |
| csr_addr | input | 6 | Register word address |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| up_valid | input | 1 | Upstream record valid |
| up_level | input | 6 | Upstream level |
| up_rset | input | 6 | Upstream register-set number |
| up_nmi | input | 1 | Upstream non-maskable flag |
| up_addr | input | 32 | Upstream handler address |
| rec_valid | output | 1 | Output record valid |
| rec_level | output | 6 | Winning level |
| rec_rset | output | 6 | Winning register-set number |
| rec_nmi | output | 1 | Winning non-maskable flag |
| rec_addr | output | 32 | Handler address |

## Verification
Corrupted state in this block shows up one clock after the stimulus that exposes it:

- A bad enable bit or level field shows as the wrong winner, a missing record or a spurious record.
- A bad base or spacing register shows as a wrong handler address.

The bench sweeps every single line and every pair of lines against an arithmetic model, under all four spacings. It also sweeps upstream levels against a local candidate. Any misordered comparison or off-by-one in the tie rules therefore surfaces on the very next sampled record.

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl #(
  parameter int N_IRQ = 32,
  parameter int LVL_W = 6,
  parameter int RS_W  = 6,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq,
  input  logic [5:0]       csr_addr,
  input  logic             csr_wr,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  input  logic             up_valid,
  input  logic [LVL_W-1:0] up_level,
  input  logic [RS_W-1:0]  up_rset,
  input  logic             up_nmi,
  input  logic [AW-1:0]    up_addr,
  output logic             rec_valid,
  output logic [LVL_W-1:0] rec_level,
  output logic [RS_W-1:0]  rec_rset,
  output logic             rec_nmi,
  output logic [AW-1:0]    rec_addr
);
  localparam int IDX_W   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int NMI_BIT = LVL_W + RS_W;
  localparam logic [5:0] A_ENSET = 6'h20;
  localparam logic [5:0] A_ENCLR = 6'h21;
  localparam logic [5:0] A_RAW   = 6'h22;
  localparam logic [5:0] A_BASE  = 6'h23;
  localparam logic [5:0] A_SPACE = 6'h24;

  logic [LVL_W-1:0] lvl_q [N_IRQ];
  logic [RS_W-1:0]  rs_q  [N_IRQ];
  logic [N_IRQ-1:0] nmi_q;
  logic [N_IRQ-1:0] en_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IRQ; i++) begin
        lvl_q[i] <= '0;
        rs_q[i]  <= '0;
      end
      nmi_q  <= '0;
      en_q   <= '0;
      base_q <= '0;
      sp_q   <= '0;
    end else if (csr_wr) begin
      for (int i = 0; i < N_IRQ; i++) begin
        if (csr_addr == 6'(i)) begin
          lvl_q[i] <= csr_wdata[LVL_W-1:0];
          rs_q[i]  <= csr_wdata[NMI_BIT-1:LVL_W];
          nmi_q[i] <= csr_wdata[NMI_BIT];
        end
      end
      case (csr_addr)
        A_ENSET: en_q   <= en_q | csr_wdata[N_IRQ-1:0];
        A_ENCLR: en_q   <= en_q & ~csr_wdata[N_IRQ-1:0];
        A_BASE:  base_q <= csr_wdata[AW-1:0];
        A_SPACE: sp_q   <= csr_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (csr_addr == 6'(i))
        csr_rdata = 32'(lvl_q[i]) | (32'(rs_q[i]) << LVL_W) | (32'(nmi_q[i]) << NMI_BIT);
    end
    case (csr_addr)
      A_ENSET, A_ENCLR: csr_rdata = 32'(en_q);
      A_RAW:            csr_rdata = 32'(irq);
      A_BASE:           csr_rdata = 32'(base_q);
      A_SPACE:          csr_rdata = 32'(sp_q);
      default: ;
    endcase
  end

  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic             loc_hit;

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    loc_hit  = 1'b0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (irq[i] && en_q[i] && lvl_q[i] > best_lvl) begin
        best_lvl = lvl_q[i];
        best_idx = IDX_W'(i);
        loc_hit  = 1'b1;
      end
    end
  end

  wire          take_up  = up_valid && (!loc_hit || up_level > best_lvl);
  wire [AW-1:0] loc_addr = base_q + (AW'(best_idx) << (3'd4 + 3'(sp_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_level <= '0;
      rec_rset  <= '0;
      rec_nmi   <= 1'b0;
      rec_addr  <= '0;
    end else if (take_up) begin
      rec_valid <= 1'b1;
      rec_level <= up_level;
      rec_rset  <= up_rset;
      rec_nmi   <= up_nmi;
      rec_addr  <= up_addr;
    end else if (loc_hit) begin
      rec_valid <= 1'b1;
      rec_level <= best_lvl;
      rec_rset  <= rs_q[best_idx];
      rec_nmi   <= nmi_q[best_idx];
      rec_addr  <= loc_addr;
    end else begin
      rec_valid <= 1'b0;
      rec_level <= '0;
      rec_rset  <= '0;
      rec_nmi   <= 1'b0;
      rec_addr  <= '0;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
`timescale 1ns/1ps
module irq_vector_ctrl_chk #(
  parameter int N_IRQ = 32,
  parameter int LVL_W = 6,
  parameter int RS_W  = 6,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IRQ-1:0] irq,
  input logic [N_IRQ-1:0] en,
  input logic             up_valid,
  input logic [LVL_W-1:0] up_level,
  input logic [AW-1:0]    up_addr,
  input logic             rec_valid,
  input logic [LVL_W-1:0] rec_level,
  input logic [RS_W-1:0]  rec_rset,
  input logic             rec_nmi,
  input logic [AW-1:0]    rec_addr
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> (rec_level == '0 && rec_rset == '0 && !rec_nmi && rec_addr == '0));

  p_up_forces_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(up_valid)) |-> rec_valid);

  p_up_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(up_valid && ((irq & en) == '0)))
      |-> (rec_addr == $past(up_addr) && rec_level == $past(up_level)));

  p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!up_valid && ((irq & en) == '0))) |-> !rec_valid);

  p_local_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rec_valid && !$past(up_valid)) |-> rec_level != '0);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .N_IRQ(N_IRQ), .LVL_W(LVL_W), .RS_W(RS_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .en(en_q),
  .up_valid(up_valid), .up_level(up_level), .up_addr(up_addr),
  .rec_valid(rec_valid), .rec_level(rec_level), .rec_rset(rec_rset),
  .rec_nmi(rec_nmi), .rec_addr(rec_addr)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic [5:0]  csr_addr = '0;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        up_valid = 1'b0;
  logic [5:0]  up_level = '0;
  logic [5:0]  up_rset = '0;
  logic        up_nmi = 1'b0;
  logic [31:0] up_addr = '0;
  logic        rec_valid;
  logic [5:0]  rec_level;
  logic [5:0]  rec_rset;
  logic        rec_nmi;
  logic [31:0] rec_addr;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .up_valid(up_valid), .up_level(up_level), .up_rset(up_rset), .up_nmi(up_nmi), .up_addr(up_addr),
    .rec_valid(rec_valid), .rec_level(rec_level), .rec_rset(rec_rset), .rec_nmi(rec_nmi), .rec_addr(rec_addr)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [5:0]  m_lvl [32];
  logic [5:0]  m_rs  [32];
  logic        m_nmi [32];
  logic [31:0] m_en;
  logic [31:0] m_base;
  logic [1:0]  m_sp;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  function automatic logic [50:0] model(input logic [31:0] rq, input logic uv, input logic [5:0] ul,
                                        input logic [5:0] ur, input logic un, input logic [31:0] ua);
    logic [5:0] bl = 0;
    int bi = 0;
    bit hit = 0;
    for (int k = 0; k < 32; k++)
      if (rq[k] && m_en[k] && m_lvl[k] > bl) begin bl = m_lvl[k]; bi = k; hit = 1; end
    if (uv && (!hit || ul > bl)) return {1'b1, ul, ur, un, ua};
    if (hit) return {1'b1, bl, m_rs[bi], m_nmi[bi], m_base + 32'(bi) * (32'd16 << m_sp)};
    return '0;
  endfunction

  task automatic apply(input string req, input logic [31:0] rq, input logic uv, input logic [5:0] ul,
                       input logic [5:0] ur, input logic un, input logic [31:0] ua);
    @(negedge clk);
    irq = rq; up_valid = uv; up_level = ul; up_rset = ur; up_nmi = un; up_addr = ua;
    @(negedge clk);
    check(req, {13'b0, rec_valid, rec_level, rec_rset, rec_nmi, rec_addr}, {13'b0, model(rq, uv, ul, ur, un, ua)});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 32; k++) begin m_lvl[k] = 0; m_rs[k] = 0; m_nmi[k] = 0; end
    m_en = 0; m_base = 0; m_sp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rec", {13'b0, rec_valid, rec_level, rec_rset, rec_nmi, rec_addr}, 64'd0);
    rd(6'h20, d); check("R1 enable", d, 0);
    rd(6'd0, d);  check("R1 cfg0", d, 0);
    rd(6'd31, d); check("R1 cfg31", d, 0);

    wr(6'd5, 32'hFFFF_FFFF);
    rd(6'd5, d); check("R2 mask", d, 32'h1FFF);
    for (int k = 0; k < 32; k++) begin
      m_lvl[k] = 6'((k * 13) % 7);
      m_rs[k]  = 6'((k * 5) % 64);
      m_nmi[k] = k[0];
      wr(6'(k), {19'h7FFFF, m_nmi[k], m_rs[k], m_lvl[k]});
    end
    for (int k = 0; k < 32; k++) begin
      rd(6'(k), d); check("R2 cfg", d, {19'b0, m_nmi[k], m_rs[k], m_lvl[k]});
    end

    wr(6'h20, 32'hF0F0_00FF);
    rd(6'h20, d); check("R3 set", d, 32'hF0F0_00FF);
    wr(6'h21, 32'h0000_000F);
    rd(6'h21, d); check("R3 clear", d, 32'hF0F0_00F0);
    wr(6'h21, 32'hFFFF_FFFF);
    rd(6'h20, d); check("R3 clear all", d, 32'h0);

    irq = 32'hA5A5_5A5A;
    rd(6'h22, d); check("R4 raw", d, 32'hA5A5_5A5A);
    @(negedge clk);
    check("R5 all masked", {31'b0, rec_valid}, 0);
    check("R10 idle fields", {26'b0, rec_level, rec_rset, rec_nmi, rec_addr}, 0);

    apply("R11 idle", 32'h0, 0, 0, 0, 0, 0);
    wr(6'h20, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
    wr(6'h23, 32'h1000_0000); m_base = 32'h1000_0000;
    @(negedge clk);
    irq = 32'h0000_0002;
    #2 check("R11 before edge", {31'b0, rec_valid}, 0);
    @(negedge clk);
    check("R11 after edge", {31'b0, rec_valid}, 1);

    for (int s = 0; s < 4; s++) begin
      wr(6'h24, 32'(s)); m_sp = 2'(s);
      for (int k = 0; k < 32; k++) apply("R8 single", 32'(1) << k, 0, 0, 0, 0, 0);
    end
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        apply("R6 pair", (32'(1) << i) | (32'(1) << j), 0, 0, 0, 0, 0);

    wr(6'h21, 32'h00FF_00FF); m_en = 32'hFF00_FF00;
    apply("R5 partly masked", 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    apply("R5 masked only", 32'h00FF_00FF, 0, 0, 0, 0, 0);
    apply("R7 nmi", 32'h0000_0200, 0, 0, 0, 0, 0);
    wr(6'h20, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;

    for (int ul = 0; ul < 64; ul++) begin
      apply("R9 up vs local", 32'h0000_0040, 1, 6'(ul), 6'h2A, ul[0], 32'hDEAD_0000 + 32'(ul));
      apply("R9 up only", 32'h0000_0001, 1, 6'(ul), 6'h15, 1'b1, 32'h0BAD_F00D);
    end
    apply("R10 final idle", 32'h0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule